// File: doc/BRIEF.md
# Single-Command Bus Requester

This block sits between a user port and a shared bus and moves one item of data at a time. A user asks for a read by pulsing `usr_get` with an address, or asks for a write by pulsing `usr_put` with an address and a data word. The block stores the request, requests the bus with a one-cycle pulse, and expects the grant exactly one cycle later. In the cycle after the grant it raises a read or write command. In the cycle after the command it drives the address, together with the write data for a write, or captures the returned word for a read.

If the grant does not arrive in its expected cycle, the block requests again on the next cycle and keeps the stored request. `usr_busy` covers the whole transaction, so the user must wait until it falls before making a new request. A one-cycle `usr_done` pulse reports that the transaction has finished. For a read, the captured word is already visible on `usr_rdata` in that same cycle.

Top module: `cmd_bus_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every output is low and `usr_rdata` is zero.
- R2: A request made while `usr_busy` is low is stored at that clock edge. `usr_busy` is high from the next cycle until the cycle in which `usr_done` is high, and it is low in that cycle.
- R3: `bus_request` is high for exactly one cycle, which is the cycle after the request was accepted or after a missed grant. It is never high in two consecutive cycles.
- R4: `bus_grant` is sampled only in the cycle right after `bus_request`. When it is high there, the command is raised in the following cycle.
- R5: When `bus_grant` is low in the cycle after `bus_request`, `bus_request` is raised again in the next cycle, and the stored address, data and direction are kept.
- R6: `cmd_rd` is raised for a stored read and `cmd_wr` for a stored write, each for one cycle. The two are never high together.
- R7: `bus_addr_vld` is high, with the stored address on `bus_addr`, exactly in the cycle after a command. In every other cycle `bus_addr_vld` is low and `bus_addr` is zero.
- R8: For a write, `bus_wdata_vld` is high, with the stored word on `bus_wdata`, in the cycle after `cmd_wr`. In every other cycle `bus_wdata_vld` is low and `bus_wdata` is zero.
- R9: For a read, `bus_rdata` is loaded into `usr_rdata` at the end of the cycle after `cmd_rd`, but only if `bus_rdata_vld` is high in that cycle. At all other times `usr_rdata` holds its value.
- R10: `usr_done` is a single-cycle pulse in the cycle after the address cycle, for both reads and writes.
- R11: `usr_get` and `usr_put` have no effect while `usr_busy` is high.
- R12: When `usr_get` and `usr_put` arrive in the same cycle, the read is taken and the write is dropped.
- R13: `bus_grant` has no effect in any cycle other than the one right after `bus_request`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_get | input | 1 | Read request pulse |
| usr_get_addr | input | AW | Read address |
| usr_put | input | 1 | Write request pulse |
| usr_put_addr | input | AW | Write address |
| usr_wdata | input | DW | Word to write |
| usr_rdata | output | DW | Last word read |
| usr_busy | output | 1 | Transaction in flight |
| usr_done | output | 1 | Completion pulse |
| bus_request | output | 1 | Bus request pulse |
| bus_grant | input | 1 | Bus grant |
| cmd_rd | output | 1 | Read command |
| cmd_wr | output | 1 | Write command |
| bus_addr | output | AW | Address on the bus |
| bus_addr_vld | output | 1 | Address qualifier |
| bus_wdata | output | DW | Write beat |
| bus_wdata_vld | output | 1 | Write beat qualifier |
| bus_rdata | input | DW | Read beat |
| bus_rdata_vld | input | 1 | Read beat qualifier |

## Verification
The bench builds the block with its default widths: an 8-bit address and a 64-bit data word. The address and data patterns it uses reach the top bits of both buses, so a lane that is dropped or swapped shows up in the compared values. Timing is exercised through grant denials, a grant held high permanently, a read whose beat never comes, simultaneous and mid-transaction requests, and a new request made in the completion cycle.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int unsigned CBM_AW_DEF = 8;
    localparam int unsigned CBM_DW_DEF = 64;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_REQ   = 3'd1,
        PH_GWAIT = 3'd2,
        PH_CMD   = 3'd3,
        PH_XFER  = 3'd4
    } phase_e;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    typedef struct packed {
        logic req;
        logic cmd;
        logic xfer;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_phase(phase_e ph);
        bus_ctl_t c;
        c.req  = (ph == PH_REQ);
        c.cmd  = (ph == PH_CMD);
        c.xfer = (ph == PH_XFER);
        return c;
    endfunction

    function automatic logic phase_busy(phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/cbm_req_latch.sv
module cbm_req_latch
    import cbm_pkg::*;
#(
    parameter int unsigned AW = CBM_AW_DEF,
    parameter int unsigned DW = CBM_DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  logic          usr_get,
    input  logic [AW-1:0] usr_get_addr,
    input  logic          usr_put,
    input  logic [AW-1:0] usr_put_addr,
    input  logic [DW-1:0] usr_wdata,
    output logic          accept,
    output op_e           op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);

    assign accept = idle && (usr_get || usr_put);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_RD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            if (usr_get) begin
                op_q   <= OP_RD;
                addr_q <= usr_get_addr;
            end else begin
                op_q    <= OP_WR;
                addr_q  <= usr_put_addr;
                wdata_q <= usr_wdata;
            end
        end
    end

endmodule

// File: rtl/cbm_sequencer.sv
module cbm_sequencer
    import cbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   gnt,
    output phase_e phase,
    output logic   done
);

    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (accept) phase_nx = PH_REQ;
            PH_REQ:   phase_nx = PH_GWAIT;
            PH_GWAIT: phase_nx = gnt ? PH_CMD : PH_REQ;
            PH_CMD:   phase_nx = PH_XFER;
            PH_XFER:  phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_XFER);
        end
    end

endmodule

// File: rtl/cbm_bus_drive.sv
module cbm_bus_drive
    import cbm_pkg::*;
#(
    parameter int unsigned AW = CBM_AW_DEF,
    parameter int unsigned DW = CBM_DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ctl_t      ctl,
    input  op_e           op,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    input  logic [DW-1:0] rdata,
    input  logic          rdata_vld,
    output logic          cmd_rd,
    output logic          cmd_wr,
    output logic [AW-1:0] bus_addr,
    output logic          addr_vld,
    output logic [DW-1:0] bus_wdata,
    output logic          wdata_vld,
    output logic [DW-1:0] rbuf
);

    logic is_wr;
    assign is_wr = (op == OP_WR);

    always_comb begin
        cmd_rd    = ctl.cmd && !is_wr;
        cmd_wr    = ctl.cmd && is_wr;
        addr_vld  = ctl.xfer;
        bus_addr  = ctl.xfer ? addr_q : '0;
        wdata_vld = ctl.xfer && is_wr;
        bus_wdata = (ctl.xfer && is_wr) ? wdata_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf <= '0;
        end else if (ctl.xfer && !is_wr && rdata_vld) begin
            rbuf <= rdata;
        end
    end

endmodule

// File: rtl/cmd_bus_master.sv
module cmd_bus_master
    import cbm_pkg::*;
#(
    parameter int unsigned AW = CBM_AW_DEF,
    parameter int unsigned DW = CBM_DW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          usr_get,
    input  logic [AW-1:0] usr_get_addr,
    input  logic          usr_put,
    input  logic [AW-1:0] usr_put_addr,
    input  logic [DW-1:0] usr_wdata,
    output logic [DW-1:0] usr_rdata,
    output logic          usr_busy,
    output logic          usr_done,
    output logic          bus_request,
    input  logic          bus_grant,
    output logic          cmd_rd,
    output logic          cmd_wr,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_vld,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_vld,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdata_vld
);

    phase_e        phase;
    bus_ctl_t      ctl;
    logic          accept;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign ctl         = decode_phase(phase);
    assign usr_busy    = phase_busy(phase);
    assign bus_request = ctl.req;

    cbm_req_latch #(.AW(AW), .DW(DW)) i_latch (
        .clk          (clk),
        .rst          (rst),
        .idle         (!usr_busy),
        .usr_get      (usr_get),
        .usr_get_addr (usr_get_addr),
        .usr_put      (usr_put),
        .usr_put_addr (usr_put_addr),
        .usr_wdata    (usr_wdata),
        .accept       (accept),
        .op_q         (op_q),
        .addr_q       (addr_q),
        .wdata_q      (wdata_q)
    );

    cbm_sequencer i_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .gnt    (bus_grant),
        .phase  (phase),
        .done   (usr_done)
    );

    cbm_bus_drive #(.AW(AW), .DW(DW)) i_drive (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .op        (op_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata     (bus_rdata),
        .rdata_vld (bus_rdata_vld),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .bus_addr  (bus_addr),
        .addr_vld  (bus_addr_vld),
        .bus_wdata (bus_wdata),
        .wdata_vld (bus_wdata_vld),
        .rbuf      (usr_rdata)
    );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
    parameter int unsigned DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] usr_rdata,
    input logic          usr_busy,
    input logic          usr_done,
    input logic          bus_request,
    input logic          bus_grant,
    input logic          cmd_rd,
    input logic          cmd_wr,
    input logic          bus_addr_vld,
    input logic          bus_wdata_vld
);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(cmd_rd && cmd_wr)); // R6

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_request |=> !bus_request); // R3

    AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_request) && bus_grant) |=> (cmd_rd || cmd_wr)); // R4

    AST_RETRY_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_request) && !bus_grant) |=> bus_request); // R5

    AST_ADDR_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd || cmd_wr) |=> bus_addr_vld); // R7

    AST_ADDR_ONLY_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        bus_addr_vld |-> $past(cmd_rd || cmd_wr)); // R7

    AST_WBEAT_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        bus_wdata_vld |-> $past(cmd_wr)); // R8

    AST_RBUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(usr_rdata) |-> usr_done); // R9

    AST_DONE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        bus_addr_vld |=> usr_done); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        usr_done |=> !usr_done); // R10

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        usr_done |-> !usr_busy); // R2

endmodule

bind cmd_bus_master cbm_checker #(.DW(DW)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .usr_rdata     (usr_rdata),
    .usr_busy      (usr_busy),
    .usr_done      (usr_done),
    .bus_request   (bus_request),
    .bus_grant     (bus_grant),
    .cmd_rd        (cmd_rd),
    .cmd_wr        (cmd_wr),
    .bus_addr_vld  (bus_addr_vld),
    .bus_wdata_vld (bus_wdata_vld)
);

// File: tb/test_cmd_bus_master.sv
module test_cmd_bus_master;

    localparam int AW = 8;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          usr_get, usr_put;
    logic [AW-1:0] usr_get_addr, usr_put_addr;
    logic [DW-1:0] usr_wdata, usr_rdata;
    logic          usr_busy, usr_done, bus_request, bus_grant;
    logic          cmd_rd, cmd_wr, bus_addr_vld, bus_wdata_vld, bus_rdata_vld;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    cmd_bus_master #(.AW(AW), .DW(DW)) i_cmd_bus_master (
        .clk(clk), .rst(rst),
        .usr_get(usr_get), .usr_get_addr(usr_get_addr),
        .usr_put(usr_put), .usr_put_addr(usr_put_addr),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
        .usr_busy(usr_busy), .usr_done(usr_done),
        .bus_request(bus_request), .bus_grant(bus_grant),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .bus_addr(bus_addr), .bus_addr_vld(bus_addr_vld),
        .bus_wdata(bus_wdata), .bus_wdata_vld(bus_wdata_vld),
        .bus_rdata(bus_rdata), .bus_rdata_vld(bus_rdata_vld)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string scen = "R1";

    // behavioural reference: step 0 idle, 1 request, 2 grant window, 3 command, 4 address/data
    int            m_step = 0;
    bit            m_rd = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [DW-1:0] m_rbuf = '0;
    bit            m_done = 1'b0;
    int            deny = 0;
    bit            force_gnt = 1'b0;
    bit            dv_en = 1'b1;

    function automatic logic [DW-1:0] pattern(logic [AW-1:0] a);
        return {8{a}} ^ 64'hA5C3_0F1E_9B7D_2468;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", req, scen, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 busy",       DW'(usr_busy),      DW'(m_step != 0));
        check("R3 bus_request", DW'(bus_request),  DW'(m_step == 1));
        check("R6 cmd_rd",     DW'(cmd_rd),        DW'(m_step == 3 && m_rd));
        check("R6 cmd_wr",     DW'(cmd_wr),        DW'(m_step == 3 && !m_rd));
        check("R7 addr_vld",   DW'(bus_addr_vld),  DW'(m_step == 4));
        check("R7 addr",       DW'(bus_addr),      (m_step == 4) ? DW'(m_addr) : '0);
        check("R8 wdata_vld",  DW'(bus_wdata_vld), DW'(m_step == 4 && !m_rd));
        check("R8 wdata",      bus_wdata,          (m_step == 4 && !m_rd) ? m_wdata : '0);
        check("R9 rdata",      usr_rdata,          m_rbuf);
        check("R10 done",      DW'(usr_done),      DW'(m_done));
    endtask

    task automatic step(bit g, logic [AW-1:0] ga, bit p, logic [AW-1:0] pa, logic [DW-1:0] wd);
        bit gnt_now;
        usr_get = g; usr_get_addr = ga;
        usr_put = p; usr_put_addr = pa; usr_wdata = wd;
        gnt_now = force_gnt || (m_step == 2 && deny == 0);
        bus_grant = gnt_now;
        bus_rdata_vld = (m_step == 4) && m_rd && dv_en;
        bus_rdata = pattern(m_addr);
        #1;
        compare_all();
        @(posedge clk);
        m_done = (m_step == 4);
        case (m_step)
            0: if (g || p) begin
                m_rd = g;
                m_addr = g ? ga : pa;
                if (!g) m_wdata = wd;
                m_step = 1;
            end
            1: m_step = 2;
            2: if (gnt_now) m_step = 3;
               else begin m_step = 1; if (deny > 0) deny--; end
            3: m_step = 4;
            4: begin
                if (m_rd && dv_en) m_rbuf = pattern(m_addr);
                m_step = 0;
            end
            default: m_step = 0;
        endcase
        @(negedge clk);
    endtask

    task automatic idle_steps(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0);
    endtask

    initial begin
        rst = 1'b1;
        usr_get = 0; usr_put = 0; usr_get_addr = '0; usr_put_addr = '0;
        usr_wdata = '0; bus_grant = 0; bus_rdata = '0; bus_rdata_vld = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check("R1 busy", DW'(usr_busy), '0);
        check("R1 bus_request", DW'(bus_request), '0);
        check("R1 rdata", usr_rdata, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done", DW'(usr_done), '0);
        check("R1 addr_vld", DW'({cmd_rd, cmd_wr, bus_addr_vld, bus_wdata_vld}), '0);

        scen = "R2 R4 read";
        step(1, 8'h12, 0, '0, '0); idle_steps(6);

        scen = "R6 R8 write";
        step(0, '0, 1, 8'hA7, 64'hDEAD_BEEF_0123_4567); idle_steps(6);

        scen = "R5 grant denied twice";
        deny = 2;
        step(1, 8'h3C, 0, '0, '0); idle_steps(10);

        scen = "R12 both at once";
        step(1, 8'hC1, 1, 8'h5E, 64'hFFFF_0000_FFFF_0000); idle_steps(6);

        scen = "R11 requests while busy";
        step(0, '0, 1, 8'hE4, 64'h0123_4567_89AB_CDEF);
        for (int i = 0; i < 4; i++) step(1, 8'h99, 1, 8'h66, 64'h1111_2222_3333_4444);
        idle_steps(4);

        scen = "R9 read beat missing";
        dv_en = 1'b0;
        step(1, 8'h77, 0, '0, '0); idle_steps(6);
        dv_en = 1'b1;

        scen = "R13 grant held high";
        force_gnt = 1'b1;
        idle_steps(2);
        step(0, '0, 1, 8'h01, 64'h8000_0000_0000_0001); idle_steps(6);
        force_gnt = 1'b0;

        scen = "R10 back-to-back";
        step(1, 8'hFE, 0, '0, '0); idle_steps(4);
        step(0, '0, 1, 8'h80, 64'hCAFE_F00D_8765_4321); idle_steps(6);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule